// File: doc/BRIEF.md
# Byte String Load with Terminator Match

The unit copies a run of bytes from a byte-wide memory into the register file, packing four bytes per 32-bit register from the most significant lane down. It moves one byte per accepted memory read. It ends either when the requested number of bytes has been moved or as soon as a moved byte equals a terminator value given at start. When it ends, it pulses a completion flag together with the number of bytes that came before the terminator. If no terminator is found, that number is the full requested count.

Two guard register indices protect registers from being overwritten. A byte whose destination register is guarded is still fetched, and it still advances the address, the lane and the count. Only the register write is dropped. Guard A is ignored when it is zero, and guard B is always active. A caller issues a one-cycle start with all parameters. It services the memory request/acknowledge port and exposes one register through a combinational read-modify-write port.

Top module: `strcmp_loader`

## Requirements
- R1: Destination lanes are filled in the order bits 31:24, 23:16, 15:8, 7:0. After lane 7:0 the next byte goes to bits 31:24 of the next register, and the register index wraps from 31 to 0.
- R2: A byte write changes only its own 8-bit lane. The other 24 bits keep the value read on `rf_rdata`.
- R3: When the current register equals guard B, or equals guard A with guard A nonzero, the byte is fetched but `rf_we` stays low. Address, lane and count advance as usual.
- R4: When a fetched byte equals the terminator, that byte is still written (unless guarded). The run then stops, and `done_count` equals the zero-based position of that byte.
- R5: With no terminator match, all `byte_cnt` bytes are moved and `done_count` equals `byte_cnt`.
- R6: The memory address starts at `start_addr` and rises by 1 per accepted byte, wrapping modulo 2^32. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R7: A start with `byte_cnt` of 0 raises `done` on the next cycle with `done_count` 0, and `mem_req` is never raised.
- R8: `done` is high for exactly one cycle per run, with `done_count` valid in that cycle. A `start` while a run is in progress is ignored.
- R9: A guard A of 0 disables guard A, so register 0 is written when a run wraps onto it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | 32 | First byte address |
| start_reg | input | 5 | First destination register |
| guard_a | input | 5 | Guard register A, inactive when 0 |
| guard_b | input | 5 | Guard register B, always active |
| byte_cnt | input | 8 | Maximum number of bytes to move |
| cmp_byte | input | 8 | Terminator value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_ack | input | 1 | Read accepted, `mem_rdata` valid |
| mem_rdata | input | 8 | Read byte |
| rf_idx | output | 5 | Register being updated |
| rf_rdata | input | 32 | Current value of register `rf_idx` |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | 32 | Merged register value |
| done | output | 1 | Run finished, one-cycle pulse |
| done_count | output | 8 | Bytes moved before the terminator, or the full count |

## Verification
The count limit and the terminator match can both fire on the same accepted byte. This is provoked by placing the terminator at the last permitted position, and the check expects the match to win with `done_count` one less than `byte_cnt`. A guarded write and a match can also fall in the same cycle. A run whose terminator lands in a guarded register must stop at that position and leave the register untouched. Memory stalls are mixed into one run to show that these outcomes depend only on accepted bytes.

// File: rtl/strcmp_loader.sv
module strcmp_loader #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [4:0]    start_reg,
  input  logic [4:0]    guard_a,
  input  logic [4:0]    guard_b,
  input  logic [CW-1:0] byte_cnt,
  input  logic [7:0]    cmp_byte,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic [4:0]    rf_idx,
  input  logic [31:0]   rf_rdata,
  output logic          rf_we,
  output logic [31:0]   rf_wdata,
  output logic          done,
  output logic [CW-1:0] done_count
);

  logic          busy;
  logic [AW-1:0] addr_q;
  logic [4:0]    reg_q, ga_q, gb_q;
  logic [1:0]    lane_q;
  logic [CW-1:0] idx_q, tot_q;
  logic [7:0]    cmp_q;

  wire       take    = busy & mem_ack;
  wire       guarded = (reg_q == gb_q) | ((ga_q != 5'd0) & (reg_q == ga_q));
  wire       hit     = (mem_rdata == cmp_q);
  wire       last    = ((idx_q + CW'(1)) == tot_q);
  wire [4:0] sh      = {~lane_q, 3'b000};

  assign mem_req  = busy;
  assign mem_addr = addr_q;
  assign rf_idx   = reg_q;
  assign rf_we    = take & ~guarded;
  assign rf_wdata = (rf_rdata & ~(32'hFF << sh)) | ({24'd0, mem_rdata} << sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      addr_q     <= '0;
      reg_q      <= '0;
      ga_q       <= '0;
      gb_q       <= '0;
      lane_q     <= '0;
      idx_q      <= '0;
      tot_q      <= '0;
      cmp_q      <= '0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          tot_q <= byte_cnt;
          if (byte_cnt == '0) begin
            done       <= 1'b1;
            done_count <= '0;
          end else begin
            busy   <= 1'b1;
            addr_q <= start_addr;
            reg_q  <= start_reg;
            ga_q   <= guard_a;
            gb_q   <= guard_b;
            cmp_q  <= cmp_byte;
            lane_q <= 2'd0;
            idx_q  <= '0;
          end
        end
      end else if (take) begin
        if (hit) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          done_count <= idx_q;
        end else if (last) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          done_count <= tot_q;
        end else begin
          addr_q <= addr_q + AW'(1);
          lane_q <= lane_q + 2'd1;
          idx_q  <= idx_q + CW'(1);
          if (lane_q == 2'd3) reg_q <= reg_q + 5'd1;
        end
      end
    end
  end

  assert_guard_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_idx != gb_q) && !((ga_q != 5'd0) && (rf_idx == ga_q)));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy && mem_ack)) |-> mem_addr == $past(mem_addr) + AW'(1));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));

  assert_zero_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && byte_cnt == '0) |=> done && done_count == '0 && !mem_req);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !rf_we);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= tot_q);

endmodule

// File: tb/sim_strcmp_loader.sv
module sim_strcmp_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [4:0]  start_reg = '0, guard_a = '0, guard_b = '0;
  logic [7:0]  byte_cnt = '0, cmp_byte = '0;
  logic        mem_req, mem_ack, rf_we, done;
  logic [31:0] mem_addr, rf_rdata, rf_wdata;
  logic [7:0]  mem_rdata, done_count;
  logic [4:0]  rf_idx;
  logic        stall_en = 1'b0;
  int          cyc = 0;
  int          checks = 0, fails = 0;
  logic [31:0] last_addr = '0;

  logic [7:0]  mem [256];
  logic [31:0] rf [32];
  logic [31:0] exp_rf [32];

  always #10 clk = ~clk;

  assign mem_ack   = mem_req & ~(stall_en & cyc[0]);
  assign mem_rdata = mem[mem_addr[7:0]];
  assign rf_rdata  = rf[rf_idx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_we) rf[rf_idx] <= rf_wdata;
    if (mem_req && mem_ack) last_addr <= mem_addr;
  end

  strcmp_loader u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(input [31:0] a, input [4:0] r, input [4:0] ga, input [4:0] gb,
                       input [7:0] n, input [7:0] cmp, output [7:0] cnt);
    for (int k = 0; k < 32; k++) exp_rf[k] = rf[k];
    cnt = n;
    for (int i = 0; i < n; i++) begin
      logic [31:0] ad;
      logic [4:0]  rg;
      logic [7:0]  b;
      ad = a + 32'(i);
      b  = mem[ad[7:0]];
      rg = r + 5'(i / 4);
      if (!(rg == gb || (ga != 0 && rg == ga)))
        exp_rf[rg][31 - 8*(i % 4) -: 8] = b;
      if (b == cmp) begin
        cnt = 8'(i);
        break;
      end
    end
  endtask

  task automatic pulse(input [31:0] a, input [4:0] r, input [4:0] ga, input [4:0] gb,
                       input [7:0] n, input [7:0] cmp);
    start_addr = a; start_reg = r; guard_a = ga; guard_b = gb; byte_cnt = n; cmp_byte = cmp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, output [7:0] cnt, output bit seen);
    seen = 0; cnt = 0;
    for (int t = 0; t < 2000; t++) begin
      if (done) begin seen = 1; cnt = done_count; break; end
      @(negedge clk);
    end
    chk(seen, req, "done timeout", 0, 1);
  endtask

  task automatic run(input string req, input [31:0] a, input [4:0] r, input [4:0] ga,
                     input [4:0] gb, input [7:0] n, input [7:0] cmp, input bit stray_start);
    logic [7:0] ecnt, acnt;
    bit seen;
    int bad;
    model(a, r, ga, gb, n, cmp, ecnt);
    pulse(a, r, ga, gb, n, cmp);
    if (stray_start) begin
      @(negedge clk);
      pulse(32'h40, 5'd9, 5'd0, 5'd31, 8'd0, 8'h00);
    end
    wait_done(req, acnt, seen);
    chk(acnt == ecnt, req, "count", acnt, ecnt);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    bad = 0;
    for (int k = 0; k < 32; k++) if (rf[k] !== exp_rf[k]) begin
      bad++;
      chk(0, req, $sformatf("rf[%0d]", k), rf[k], exp_rf[k]);
    end
    if (bad == 0) chk(1, req, "rf", 0, 0);
    if (stray_start) begin
      repeat (4) @(negedge clk);
      chk(!done, "R8", "stray start accepted", done, 0);
    end
  endtask

  task automatic t_reset();
    chk(!done && !mem_req && !rf_we, "R8", "reset outputs", {done, mem_req, rf_we}, 0);
  endtask

  task automatic t_full();
    run("R5", 32'h10, 5'd3, 5'd0, 5'd31, 8'd6, mem[8'h10 + 100], 0);
    run("R1", 32'h20, 5'd7, 5'd0, 5'd31, 8'd9, mem[8'h20 + 100], 0);
  endtask

  task automatic t_match();
    run("R4", 32'h30, 5'd12, 5'd0, 5'd31, 8'd20, mem[8'h30 + 6], 0);
    run("R4", 32'h50, 5'd14, 5'd0, 5'd31, 8'd8, mem[8'h50 + 7], 0);
    run("R4", 32'h60, 5'd15, 5'd0, 5'd31, 8'd8, mem[8'h60], 0);
  endtask

  task automatic t_guard();
    run("R9", 32'h70, 5'd30, 5'd0, 5'd31, 8'd14, mem[8'h70 + 100], 0);
    chk(rf[0][31:24] == mem[8'h78], "R9", "reg0 lane", rf[0][31:24], mem[8'h78]);
    run("R3", 32'h90, 5'd30, 5'd1, 5'd30, 8'd16, mem[8'h90 + 100], 0);
    run("R3", 32'hA0, 5'd30, 5'd0, 5'd31, 8'd12, mem[8'hA0 + 5], 0);
  endtask

  task automatic t_lane();
    rf[20] = 32'h12345678;
    run("R2", 32'hB0, 5'd20, 5'd0, 5'd31, 8'd2, mem[8'hB0 + 100], 0);
    chk(rf[20][15:0] == 16'h5678, "R2", "untouched lanes", rf[20][15:0], 16'h5678);
  endtask

  task automatic t_zero();
    logic [7:0] c;
    bit seen, req_seen;
    pulse(32'h0, 5'd4, 5'd0, 5'd31, 8'd0, 8'h00);
    req_seen = mem_req;
    wait_done("R7", c, seen);
    chk(c == 0, "R7", "zero count", c, 0);
    chk(!req_seen && !mem_req, "R7", "no request", req_seen, 0);
  endtask

  task automatic t_wrap();
    run("R6", 32'hFFFF_FFFE, 5'd22, 5'd0, 5'd31, 8'd4, mem[8'hFE + 100], 0);
    chk(last_addr == 32'h1, "R6", "wrapped address", last_addr, 32'h1);
  endtask

  task automatic t_busy_stall();
    stall_en = 1'b1;
    run("R8", 32'hC0, 5'd24, 5'd0, 5'd31, 8'd10, mem[8'hC0 + 100], 1);
    stall_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 32; i++) rf[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full();
    t_match();
    t_guard();
    t_lane();
    t_zero();
    t_wrap();
    t_busy_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule